// File: doc/BRIEF.md
# Falling-Edge Loadable Right-Shift Register

This block is a small storage stage that holds a word of `WIDTH` bits (four by default). On every falling clock edge it does one of two things. It takes a fresh parallel word from its data inputs, or it moves its contents one stage further along, with a new serial bit entering at the head. A single mode line chooses between these two actions.

The last stage is always present on a serial output pin. Several copies can therefore be chained to form a longer right-shifting line: each serial output feeds the serial input of the next copy. The parallel word reaches the outside world through an output gate with an active-low enable. While that enable is high the parallel pins float, and the stages inside keep working.

An asynchronous active-low clear empties every stage at once. The clear does not wait for a clock edge.

Top module: `prs_shift_reg`

## Requirements
- R1: While `clr_n` is low, every stage holds 0, at once and with no clock edge needed.
- R2: With `ld_mode` = 1 at a falling clock edge, stage i takes `par_in[i]` for every i, and `ser_in` has no effect.
- R3: With `ld_mode` = 0 at a falling clock edge, stage 0 takes `ser_in` and stage i takes the old value of stage i-1 for i >= 1. Stage 0 is the head and stage `WIDTH-1` is the tail.
- R4: `ser_out` always equals the tail stage (bit `WIDTH-1`), whatever the level of `oe_n`.
- R5: While `oe_n` is low, `par_out[i]` shows stage i.
- R6: While `oe_n` is high, `par_out` is released to high impedance and does not drive the stored word.
- R7: The stages go on loading and shifting while `oe_n` is high. When the outputs are enabled again they show the up-to-date contents.
- R8: State changes only on the high-to-low clock transition. A rising edge or the level of the clock alone leaves the stages unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register acts on its falling edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_mode | input | 1 | 1 = parallel load, 0 = shift toward the tail |
| par_in | input | WIDTH | Parallel data; bit i goes to stage i |
| ser_in | input | 1 | Serial bit that enters stage 0 when shifting |
| oe_n | input | 1 | Output enable for `par_out`, active low |
| par_out | output | WIDTH | Gated parallel view of the stages; high impedance when disabled |
| ser_out | output | 1 | Tail stage, not gated; used for cascading |

## Verification
The properties sample on the falling edge, so they assume that the mode, parallel data and serial bit are steady around that edge. They also assume that the clear is released away from it. The stimulus meets these assumptions by changing every input just after a rising edge, half a period before the active edge. The random traffic mixes load and shift cycles with an enable that toggles freely and a rare clear, so the disabled case and recovery from a clear both occur often. When the parallel pins are disabled the simulator may show them as high impedance or as zero. For that reason the bench checks only that they no longer carry the stored word, and it always chooses a nonzero word for that check.

// File: rtl/prs_pkg.sv
package prs_pkg;

    // Action taken at the active clock edge, selected by the mode line.
    typedef enum logic {
        PRS_SHIFT = 1'b0,
        PRS_LOAD  = 1'b1
    } prs_mode_e;

endpackage

// File: rtl/prs_next_cell.sv
// Next-value selector for one stage: the parallel bit when loading,
// the preceding stage (or the serial input for the head) when shifting.
module prs_next_cell
    import prs_pkg::*;
(
    input  prs_mode_e mode_i,
    input  logic      par_bit_i,
    input  logic      prev_bit_i,
    output logic      next_bit_o
);

    always_comb begin
        unique case (mode_i)
            PRS_LOAD:  next_bit_o = par_bit_i;
            PRS_SHIFT: next_bit_o = prev_bit_i;
            default:   next_bit_o = prev_bit_i;
        endcase
    end

endmodule

// File: rtl/prs_out_gate.sv
// Parallel output driver: passes the stages while enabled, floats otherwise.
module prs_out_gate #(
    parameter int WIDTH = 4
) (
    input  logic             oe_n_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] pins_o
);

    assign pins_o = oe_n_i ? {WIDTH{1'bz}} : data_i;

endmodule

// File: rtl/prs_shift_reg.sv
module prs_shift_reg
    import prs_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out
);

    localparam int TAIL = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stage;
    } prs_state_t;

    prs_state_t       st_d;
    prs_state_t       st_q;
    prs_mode_e        mode_sel;
    logic [WIDTH-1:0] prev_bits;
    logic [WIDTH-1:0] next_bits;

    assign mode_sel = prs_mode_e'(ld_mode);

    // The serial input feeds the head; every other stage sees its predecessor.
    assign prev_bits = {st_q.stage[WIDTH-2:0], ser_in};

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        prs_next_cell u_cell (
            .mode_i     (mode_sel),
            .par_bit_i  (par_in[g]),
            .prev_bit_i (prev_bits[g]),
            .next_bit_o (next_bits[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.stage = next_bits;
    end

    always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.stage[TAIL];

    prs_out_gate #(.WIDTH(WIDTH)) u_gate (
        .oe_n_i (oe_n),
        .data_i (st_q.stage),
        .pins_o (par_out)
    );

endmodule

// File: rtl/prs_shift_reg_chk.sv
module prs_shift_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_mode,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_in,
    input logic             oe_n,
    input logic [WIDTH-1:0] par_out,
    input logic             ser_out,
    input logic [WIDTH-1:0] state
);

    // R1
    clear_empties_chk: assert property (@(negedge clk)
        !clr_n |-> state == '0);

    // R2
    load_captures_chk: assert property (@(negedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(ld_mode)) |-> state == $past(par_in));

    // R3
    shift_moves_chk: assert property (@(negedge clk) disable iff (!clr_n)
        ($past(clr_n) && !$past(ld_mode))
            |-> state == {$past(state[WIDTH-2:0]), $past(ser_in)});

    // R4
    tail_follows_chk: assert property (@(negedge clk) disable iff (!clr_n)
        ($past(clr_n) && !$past(ld_mode)) |-> ser_out == $past(state[WIDTH-2]));

    // R5
    enabled_drive_chk: assert property (@(negedge clk) disable iff (!clr_n)
        !oe_n |-> par_out == state);

endmodule

bind prs_shift_reg prs_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .ld_mode (ld_mode),
    .par_in  (par_in),
    .ser_in  (ser_in),
    .oe_n    (oe_n),
    .par_out (par_out),
    .ser_out (ser_out),
    .state   (st_q.stage)
);

// File: tb/prs_shift_reg_tb.sv
`timescale 1ns/1ps
module prs_shift_reg_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         ld_mode = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    logic         oe_n = 1'b0;
    logic [W-1:0] par_out;
    logic         ser_out;

    logic [W-1:0] exp_st = '0;
    int           checks = 0;
    int           errors = 0;

    always #2 clk = ~clk;

    prs_shift_reg #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .clr_n   (clr_n),
        .ld_mode (ld_mode),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .oe_n    (oe_n),
        .par_out (par_out),
        .ser_out (ser_out)
    );

    function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic ld,
                                                logic [W-1:0] pd, logic si);
        return ld ? pd : {cur[W-2:0], si};
    endfunction

    task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Full comparison of both outputs against the model.
    task automatic check_outputs(string tag);
        chk(ser_out === exp_st[W-1], {"R4 ", tag}, {{(W-1){1'b0}}, ser_out},
            {{(W-1){1'b0}}, exp_st[W-1]});
        if (!oe_n) chk(par_out === exp_st, {"R5 ", tag}, par_out, exp_st);
        else if (exp_st != '0)
            chk(par_out !== exp_st, {"R6 ", tag}, par_out, exp_st);
    endtask

    // Drive just after a rising edge, update the model at the falling edge,
    // sample 1 ns later.
    task automatic cycle(logic ld, logic [W-1:0] pd, logic si, logic oen, logic cn);
        @(posedge clk);
        ld_mode = ld; par_in = pd; ser_in = si; oe_n = oen; clr_n = cn;
        @(negedge clk);
        exp_st = cn ? model_next(exp_st, ld, pd, si) : '0;
        #1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        #1;
        chk(par_out === '0, "R1 reset", par_out, '0);
        cycle(1'b1, 4'b1111, 1'b1, 1'b0, 1'b0);
        chk(par_out === '0, "R1 held in clear", par_out, '0);

        // R2: load, ser_in ignored
        cycle(1'b1, 4'b1010, 1'b1, 1'b0, 1'b1);
        chk(par_out === 4'b1010, "R2 load", par_out, 4'b1010);
        cycle(1'b1, 4'b0110, 1'b0, 1'b0, 1'b1);
        chk(par_out === 4'b0110, "R2 load ser_in ignored", par_out, 4'b0110);

        // R8: a rising edge and the clock level change nothing
        @(posedge clk);
        ld_mode = 1'b1; par_in = 4'b1001;
        #1;
        chk(par_out === 4'b0110, "R8 no change before falling edge", par_out, 4'b0110);
        @(negedge clk); exp_st = 4'b1001; #1;
        chk(par_out === 4'b1001, "R8 change at falling edge", par_out, 4'b1001);

        // R3 / R4: shift ones in and walk the pattern out of the tail
        cycle(1'b0, 4'b0000, 1'b1, 1'b0, 1'b1);
        chk(par_out === 4'b0011, "R3 shift one", par_out, 4'b0011);
        cycle(1'b0, 4'b1111, 1'b0, 1'b0, 1'b1);
        chk(par_out === 4'b0110, "R3 shift zero", par_out, 4'b0110);
        for (int i = 0; i < W; i++) begin
            cycle(1'b0, 4'b0000, 1'b0, 1'b0, 1'b1);
            check_outputs("tail drain");
        end
        chk(par_out === 4'b0000, "R3 drained", par_out, 4'b0000);

        // R6 / R7 / R4: disabled outputs, internal stages keep running
        cycle(1'b1, 4'b1101, 1'b0, 1'b1, 1'b1);
        chk(par_out !== 4'b1101, "R6 released", par_out, 4'b1101);
        chk(ser_out === 1'b1, "R4 tail while disabled", {3'b000, ser_out}, 4'b0001);
        cycle(1'b0, 4'b0000, 1'b0, 1'b1, 1'b1);
        check_outputs("disabled shift");
        cycle(1'b0, 4'b0000, 1'b1, 1'b0, 1'b1);
        chk(par_out === 4'b0101, "R7 state kept while disabled", par_out, 4'b0101);

        // R1: asynchronous clear without waiting for a falling edge
        @(posedge clk);
        clr_n = 1'b0;
        #0.5;
        chk(par_out === '0, "R1 async clear", par_out, '0);
        exp_st = '0;
        @(negedge clk); #1;
        clr_n = 1'b1;

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            logic r_ld, r_si, r_oe, r_cn;
            logic [W-1:0] r_pd;
            r_ld = 1'($urandom_range(0, 1));
            r_si = 1'($urandom_range(0, 1));
            r_oe = ($urandom_range(0, 3) == 0);
            r_cn = ($urandom_range(0, 31) != 0);
            r_pd = W'($urandom);
            cycle(r_ld, r_pd, r_si, r_oe, r_cn);
            if (!r_cn) chk(par_out === '0 || r_oe, "R1 random clear", par_out, '0);
            check_outputs(r_ld ? "R2 random" : "R3 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule